// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port seen through a small word-addressed register window. Software sets a per-pin direction, drives output pins from a data latch, reads the pads, and chooses for each input pin how a pad change raises a sticky event flag. The choices are low level, high level, rising edge or falling edge. An optional per-pin override catches both edges. Flags ANDed with an enable mask are merged into an interrupt request. A build option splits that request into one line for pins 0-15 and one for pins 16-31.

The pads are sampled every clock into a pad register. A pin raises its flag when its pad value changes and the new value meets the pin's condition. Flags are also re-evaluated one clock after any write to the direction, either trigger word, the both-edge register or the flag register. This re-evaluation is what makes a level source come back after software clears it while the pad still sits at the active level. The bus is a plain synchronous strobe pair: a write takes effect at the clock edge where `wr_en_i` is sampled high, and read data appears on `rdata_o` one clock after `rd_en_i`.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `gpio_oe_o`, `gpio_o` and both IRQ outputs are 0, and no flag is set until a pad changes or a register write occurs.
- R2: `gpio_oe_o` equals the direction register (1 = output), and `gpio_o` carries the data-latch bit only on pins whose direction bit is 1, with 0 elsewhere.
- R3: A read of offset 0x00 returns the data-latch bit on output pins and the sampled pad bit on input pins.
- R4: A read of offset 0x08 returns the sampled pads with every output pin forced to 0.
- R5: Trigger words sit at 0x0C (pins 0-15) and 0x10 (pins 16-31). Each pin uses bits [2k+1:2k] of its word, where k is the pin index within its half. The encodings are 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge.
- R6: A level-configured input pin sets its flag when its pad moves to the active level, and also on each re-evaluation while the pad holds that level. Clearing such a flag therefore has no lasting effect while the level persists.
- R7: An edge-configured input pin sets its flag only on a pad change in the configured direction.
- R8: When the both-edge register (0x1C) is present and a pin's bit is 1, any pad change on that pin sets its flag, whatever its trigger code says.
- R9: A pin whose direction bit is 1 never sets its flag.
- R10: Writing the flag register (0x18) clears every flag whose data bit is 1 and leaves the others unchanged.
- R11: With `HAS_ANYEDGE` = 0, offset 0x1C reads 0 and writes to it have no effect on event detection.
- R12: With `SPLIT_IRQ` = 0, `irq_lo_o` is the OR of all flag AND mask bits and `irq_hi_o` stays 0. With `SPLIT_IRQ` = 1, `irq_lo_o` covers pins 0-15 and `irq_hi_o` covers pins 16-31. Either output changes one clock after the flag or mask change.
- R13: Offsets from 0x20 upward and offsets not a multiple of 4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (6) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid one clock after the read strobe |
| pad_i | input | DATA_W (32) | Pad levels, assumed already synchronous to clk |
| gpio_o | output | DATA_W (32) | Output pin values |
| gpio_oe_o | output | DATA_W (32) | Output enables, one per pin |
| irq_lo_o | output | 1 | Interrupt request: all pins, or pins 0-15 when split |
| irq_hi_o | output | 1 | Interrupt request for pins 16-31 when split, else 0 |

## Verification
A wrong flag bit shows on the IRQ output two clocks after the pad edge that should or should not have raised it, and on `rdata_o` at the next flag read. A mis-mapped trigger field shows as a flag appearing on the wrong pin, or on the wrong IRQ half, in the clock after the trigger write's re-evaluation. A bad direction or data latch shows on `gpio_o`/`gpio_oe_o` in the same cycle it is written, and in the mixed readback of offset 0x00 one read later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Word index of each register (byte offset / 4).
  typedef enum logic [2:0] {
    RG_DOUT   = 3'd0,
    RG_DIR    = 3'd1,
    RG_PAD    = 3'd2,
    RG_CFG_LO = 3'd3,
    RG_CFG_HI = 3'd4,
    RG_MASK   = 3'd5,
    RG_FLAG   = 3'd6,
    RG_ANY    = 3'd7
  } reg_sel_e;

  // Per-pin trigger codes: bit 1 selects edge, bit 0 selects the active polarity.
  localparam logic [1:0] TRIG_LOW  = 2'b00;
  localparam logic [1:0] TRIG_HIGH = 2'b01;
  localparam logic [1:0] TRIG_RISE = 2'b10;
  localparam logic [1:0] TRIG_FALL = 2'b11;

endpackage

// File: rtl/gpio_pin_event.sv
module gpio_pin_event (
  input  logic       pad_new,
  input  logic       pad_old,
  input  logic       is_out,
  input  logic       any_en,
  input  logic [1:0] trig,
  input  logic       reeval,
  output logic       hit
);
  import gpio_pkg::*;

  logic moved;
  assign moved = pad_new ^ pad_old;

  always_comb begin
    hit = 1'b0;
    if (!is_out) begin
      if (any_en) begin
        hit = moved;
      end else if (trig == TRIG_RISE || trig == TRIG_FALL) begin
        // Edge: a change whose new value differs from the polarity bit.
        hit = moved && (pad_new != trig[0]);
      end else begin
        // Level: evaluated on a change or on a forced re-evaluation.
        hit = (moved || reeval) && (pad_new == trig[0]);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int DATA_W    = 32,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] flag_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] pend;
  logic              lo_n;
  logic              hi_n;

  assign pend = flag_i & mask_i;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign lo_n = |pend[HALF-1:0];
      assign hi_n = |pend[DATA_W-1:HALF];
    end else begin : g_single
      assign lo_n = |pend;
      assign hi_n = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
    end else begin
      irq_lo_o <= lo_n;
      irq_hi_o <= hi_n;
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pad_i,
  output logic [DATA_W-1:0] gpio_o,
  output logic [DATA_W-1:0] gpio_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  import gpio_pkg::*;

  localparam int CFG_W = 2 * DATA_W;

  logic [DATA_W-1:0] dout_q, dir_q, pad_q, cfg_lo_q, cfg_hi_q;
  logic [DATA_W-1:0] mask_q, flag_q, any_q, rdata_q;
  logic [DATA_W-1:0] set_vec, clr_vec, rd_mux;
  logic [CFG_W-1:0]  cfg_all;
  logic              reeval_q;
  logic              in_map, wr_hit, reeval_n;
  reg_sel_e          word;

  // Decode: aligned offsets inside the 8-word window only.
  assign word   = reg_sel_e'(addr_i[4:2]);
  assign in_map = (addr_i[1:0] == 2'b00) && ((addr_i >> 5) == '0);
  assign wr_hit = wr_en_i && in_map;

  assign reeval_n = wr_hit && (word == RG_DIR || word == RG_CFG_LO ||
                               word == RG_CFG_HI || word == RG_FLAG ||
                               word == RG_ANY);

  assign cfg_all = {cfg_hi_q, cfg_lo_q};
  assign clr_vec = (wr_hit && word == RG_FLAG) ? wdata_i : '0;

  // Control registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      pad_q    <= '0;
      flag_q   <= '0;
      reeval_q <= 1'b0;
    end else begin
      if (wr_hit) begin
        case (word)
          RG_DOUT:   dout_q   <= wdata_i;
          RG_DIR:    dir_q    <= wdata_i;
          RG_CFG_LO: cfg_lo_q <= wdata_i;
          RG_CFG_HI: cfg_hi_q <= wdata_i;
          RG_MASK:   mask_q   <= wdata_i;
          default:   ;
        endcase
      end
      pad_q    <= pad_i;
      flag_q   <= (flag_q & ~clr_vec) | set_vec;
      reeval_q <= reeval_n;
    end
  end

  // Optional both-edge override register.
  generate
    if (HAS_ANYEDGE) begin : g_any
      always_ff @(posedge clk) begin
        if (rst)                             any_q <= '0;
        else if (wr_hit && word == RG_ANY)   any_q <= wdata_i;
      end
    end else begin : g_no_any
      assign any_q = '0;
    end
  endgenerate

  // Per-pin event detection.
  generate
    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
      gpio_pin_event u_evt (
        .pad_new (pad_i[p]),
        .pad_old (pad_q[p]),
        .is_out  (dir_q[p]),
        .any_en  (any_q[p]),
        .trig    (cfg_all[2*p +: 2]),
        .reeval  (reeval_q),
        .hit     (set_vec[p])
      );
    end
  endgenerate

  // Readback.
  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      case (word)
        RG_DOUT:   rd_mux = (dout_q & dir_q) | (pad_q & ~dir_q);
        RG_DIR:    rd_mux = dir_q;
        RG_PAD:    rd_mux = pad_q & ~dir_q;
        RG_CFG_LO: rd_mux = cfg_lo_q;
        RG_CFG_HI: rd_mux = cfg_hi_q;
        RG_MASK:   rd_mux = mask_q;
        RG_FLAG:   rd_mux = flag_q;
        RG_ANY:    rd_mux = any_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign gpio_o    = dout_q & dir_q;
  assign gpio_oe_o = dir_q;

  gpio_irq_merge #(
    .DATA_W    (DATA_W),
    .SPLIT_IRQ (SPLIT_IRQ)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .flag_i   (flag_q),
    .mask_i   (mask_q),
    .irq_lo_o (irq_lo_o),
    .irq_hi_o (irq_hi_o)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] gpio_o,
  input logic [DATA_W-1:0] gpio_oe_o,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [DATA_W-1:0] flag_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] dir_q,
  input logic [DATA_W-1:0] any_q,
  input logic [DATA_W-1:0] set_vec
);
  localparam int HALF = DATA_W / 2;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flag_q == '0 && !irq_lo_o && !irq_hi_o && gpio_oe_o == '0)); // R1

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    (gpio_o & ~gpio_oe_o) == '0); // R2

  AST_OUT_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (set_vec & dir_q) == '0); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(24)) |=>
      ((flag_q & $past(wdata_i) & ~$past(set_vec)) == '0)); // R10

  generate
    if (!HAS_ANYEDGE) begin : g_no_any
      AST_ANY_ABSENT: assert property (@(posedge clk) disable iff (rst)
        any_q == '0); // R11
    end
    if (SPLIT_IRQ) begin : g_split
      AST_IRQ_LO_LAT: assert property (@(posedge clk) disable iff (rst)
        irq_lo_o == $past(|(flag_q[HALF-1:0] & mask_q[HALF-1:0]))); // R12
      AST_IRQ_HI_LAT: assert property (@(posedge clk) disable iff (rst)
        irq_hi_o == $past(|(flag_q[DATA_W-1:HALF] & mask_q[DATA_W-1:HALF]))); // R12
    end else begin : g_single
      AST_IRQ_ALL_LAT: assert property (@(posedge clk) disable iff (rst)
        irq_lo_o == $past(|(flag_q & mask_q))); // R12
      AST_IRQ_HI_IDLE: assert property (@(posedge clk) disable iff (rst)
        !irq_hi_o); // R12
    end
  endgenerate

endmodule

bind gpio_port gpio_port_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .HAS_ANYEDGE (HAS_ANYEDGE),
  .SPLIT_IRQ   (SPLIT_IRQ)
) u_chk (.*);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  localparam logic [5:0] A_DOUT = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08,
                         A_CLO = 6'h0C, A_CHI = 6'h10, A_MASK = 6'h14,
                         A_FLAG = 6'h18, A_ANY = 6'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, pad = '0;
  logic [31:0] rdata0, rdata1, gpio0, oe0, gpio1, oe1;
  logic        irq_lo0, irq_hi0, irq_lo1, irq_hi1;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en & ~sel), .rd_en_i(rd_en & ~sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .pad_i(pad),
    .gpio_o(gpio0), .gpio_oe_o(oe0), .irq_lo_o(irq_lo0), .irq_hi_o(irq_hi0)
  );

  gpio_port #(.HAS_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) u1 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en & sel), .rd_en_i(rd_en & sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .pad_i(pad),
    .gpio_o(gpio1), .gpio_oe_o(oe1), .irq_lo_o(irq_lo1), .irq_hi_o(irq_hi1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = sel ? rdata1 : rdata0;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk); pad = v;
  endtask

  task automatic quiet();
    set_pad(32'h0);
    wr(A_DIR, 32'h0);
    wr(A_CLO, 32'hAAAAAAAA);
    wr(A_CHI, 32'hAAAAAAAA);
    wr(A_ANY, 32'h0);
    wr(A_MASK, 32'h0);
    wr(A_FLAG, 32'hFFFFFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(6'(i * 4), d);
      chk("R1 register reads zero after reset", d, 32'h0);
    end
    chk("R1 oe after reset", oe0, 32'h0);
    chk("R1 gpio after reset", gpio0, 32'h0);
    chk("R1 irq after reset", {30'h0, irq_hi0, irq_lo0}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    quiet();
    wr(A_DIR, 32'h0000FFFF);
    wr(A_DOUT, 32'hA5A55A5A);
    chk("R2 gpio_o gated by direction", gpio0, 32'h00005A5A);
    chk("R2 gpio_oe equals direction", oe0, 32'h0000FFFF);
    set_pad(32'h12345678);
    rd(A_DOUT, d);
    chk("R3 data readback mixes latch and pad", d, 32'h12345A5A);
    rd(A_PAD, d);
    chk("R4 pad readback hides outputs", d, 32'h12340000);
  endtask

  task automatic t_level();
    logic [31:0] d;
    quiet();
    wr(A_CLO, 32'hAAAAAA6A);            // pin 3 high level
    rd(A_FLAG, d);
    chk("R6 level inactive no flag", d, 32'h0);
    set_pad(32'h8);
    rd(A_FLAG, d);
    chk("R6 high level sets flag", d, 32'h8);
    wr(A_FLAG, 32'h8);
    rd(A_FLAG, d);
    chk("R6 level flag re-asserts after clear", d, 32'h8);
    set_pad(32'h0);
    wr(A_FLAG, 32'h8);
    rd(A_FLAG, d);
    chk("R6 flag stays clear once level gone", d, 32'h0);
    wr(A_CHI, 32'hAAAAA8AA);            // pin 20 low level
    rd(A_FLAG, d);
    chk("R5 upper word field maps to pin 20", d, 32'h00100000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    quiet();
    wr(A_CLO, 32'hAAAAAEAA);            // pin 5 falling, others rising
    set_pad(32'h220);
    rd(A_FLAG, d);
    chk("R7 rising edge only on rising pin", d, 32'h200);
    set_pad(32'h0);
    rd(A_FLAG, d);
    chk("R7 falling edge on falling pin", d, 32'h220);
    wr(A_FLAG, 32'h200);
    rd(A_FLAG, d);
    chk("R10 clear one flag keeps other", d, 32'h020);
    wr(A_FLAG, 32'h020);
    rd(A_FLAG, d);
    chk("R10 clear remaining flag", d, 32'h0);
  endtask

  task automatic t_any();
    logic [31:0] d;
    quiet();
    wr(A_ANY, 32'h80);
    rd(A_ANY, d);
    chk("R8 both-edge register stores", d, 32'h80);
    set_pad(32'h80);
    wr(A_FLAG, 32'h80);
    rd(A_FLAG, d);
    chk("R8 flag cleared before fall", d, 32'h0);
    set_pad(32'h0);
    rd(A_FLAG, d);
    chk("R8 falling edge caught despite rising code", d, 32'h80);
  endtask

  task automatic t_outpin();
    logic [31:0] d;
    quiet();
    wr(A_DIR, 32'h1);
    wr(A_CLO, 32'hAAAAAAA9);            // pin 0 high level
    set_pad(32'h1);
    rd(A_FLAG, d);
    chk("R9 output pin raises no flag", d, 32'h0);
    rd(A_PAD, d);
    chk("R4 output pin pad reads zero", d, 32'h0);
    wr(A_DIR, 32'h0);
    rd(A_FLAG, d);
    chk("R6 direction write re-evaluates level", d, 32'h1);
  endtask

  task automatic t_irq();
    quiet();
    wr(A_MASK, 32'h00010000);
    set_pad(32'h00010000);
    @(negedge clk);
    chk("R12 irq not yet raised", {31'h0, irq_lo0}, 32'h0);
    @(negedge clk);
    chk("R12 irq one clock after flag", {31'h0, irq_lo0}, 32'h1);
    chk("R12 upper irq idle when not split", {31'h0, irq_hi0}, 32'h0);
    wr(A_MASK, 32'h0);
    chk("R12 irq still high at mask edge", {31'h0, irq_lo0}, 32'h1);
    @(negedge clk);
    chk("R12 irq drops after mask", {31'h0, irq_lo0}, 32'h0);
  endtask

  task automatic t_split();
    logic [31:0] d;
    sel = 1'b1;
    quiet();
    wr(A_ANY, 32'hFFFFFFFF);
    rd(A_ANY, d);
    chk("R11 absent both-edge reads zero", d, 32'h0);
    wr(A_MASK, 32'hFFFFFFFF);
    set_pad(32'h4);
    @(negedge clk); @(negedge clk);
    chk("R12 split low irq", {30'h0, irq_hi1, irq_lo1}, 32'h1);
    wr(A_FLAG, 32'h4);
    set_pad(32'h00040004);
    @(negedge clk); @(negedge clk);
    chk("R12 split high irq", {30'h0, irq_hi1, irq_lo1}, 32'h2);
    wr(A_FLAG, 32'h00040000);
    set_pad(32'h4);
    rd(A_FLAG, d);
    chk("R11 ignored both-edge write leaves fall silent", d, 32'h0);
    sel = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    quiet();
    wr(6'h20, 32'hFFFFFFFF);
    rd(6'h20, d);
    chk("R13 offset 0x20 reads zero", d, 32'h0);
    wr(6'h05, 32'hFFFFFFFF);
    wr(6'h24, 32'hFFFFFFFF);
    rd(A_DIR, d);
    chk("R13 misaligned and high writes ignored", d, 32'h0);
    rd(6'h3C, d);
    chk("R13 offset 0x3C reads zero", d, 32'h0);
    rd(6'h06, d);
    chk("R13 misaligned read zero", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_output();
    t_level();
    t_edge();
    t_any();
    t_outpin();
    t_irq();
    t_split();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule